// File: doc/BRIEF.md
# Serial Memory Two-Wire Slave Front-End

This block is the bus-facing half of a two-wire serial memory. It takes the clock and data lines of the bus as asynchronous inputs and brings them into a faster system clock domain. It finds start and stop conditions and shifts bytes in and out, most significant bit first. It also drives the data line low through an open-drain enable, either to acknowledge or to send read data. A memory sequencer beside it receives decoded events: the select byte with the high address bit and the direction, every written data byte, every request for the next read byte, and the stop that ends an addressed transfer.

The first byte after a start is a select byte. Its top nibble must be the fixed device code `1010`. The next two bits must equal the two chip-enable inputs. Bit 1 carries memory address bit 8 and bit 0 is the read flag. If the byte does not match, the block keeps quiet until the next start. While the sequencer reports a programming cycle, or while the power-on reset is asserted, the bus is ignored entirely.

Top module: `serial_mem_bus_front`

## Requirements
- R1: A start is data falling while the clock is high. A stop is data rising while the clock is high. A stop returns the block to standby. `stopStrobe` pulses for one cycle on a stop only if a select byte has matched since the previous stop.
- R2: Data is sampled on clock rising edges, most significant bit first. After the 8th bit of each data byte in a write, `rxStrobe` pulses and `rxByte` holds the byte.
- R3: The select byte is matched when bits 7..4 equal `1010` and bits 3..2 equal `chipSel[1:0]` (bit 3 against `chipSel[1]`). On a match the block pulls data low during the 9th clock and pulses `selStrobe`. It then holds `selHiAddr` = bit 1 and `selRead` = bit 0.
- R4: On a mismatching select byte, no acknowledge is given and no strobe fires. Every following byte is ignored until the next start.
- R5: In a write transfer, every data byte is acknowledged in its 9th clock.
- R6: In a read transfer, `txByte` is loaded when `txTake` pulses. It is then driven out most significant bit first, and data is released in the 9th clock. If the master acknowledges, the next byte is loaded with another `txTake`.
- R7: After the master does not acknowledge a read byte, the block drives nothing more until a new start.
- R8: A start at any point, including mid-byte, restarts select-byte reception. This allows an address write followed by a repeated-start read.
- R9: While `progBusy` is high, the block ignores starts, acknowledges nothing, raises no strobe, and releases data. A transfer in flight is abandoned and its later stop gives no `stopStrobe`.
- R10: While `rstN` is low, `sdaPullLow` stays low and no transfer is recognised.
- R11: The pull-down only turns on while the synchronised clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rstN | input | 1 | Active-low power-on reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line as seen on the wire, asynchronous |
| chipSel | input | 2 | Chip-enable match bits; [1] against select bit 3, [0] against bit 2 |
| progBusy | input | 1 | Programming cycle in progress; bus ignored |
| txByte | input | 8 | Next read byte, taken when `txTake` pulses |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| selStrobe | output | 1 | One-cycle pulse on a matching select byte |
| selHiAddr | output | 1 | Memory address bit 8 from the last matched select |
| selRead | output | 1 | Read flag from the last matched select |
| rxStrobe | output | 1 | One-cycle pulse when a written data byte is complete |
| rxByte | output | 8 | Last written data byte |
| txTake | output | 1 | One-cycle pulse when `txByte` is loaded for sending |
| stopStrobe | output | 1 | One-cycle pulse on a stop ending an addressed transfer |

## Verification
The hardest case to reach is a transfer cut off halfway: a repeated start that lands after only a few bits of a data byte, or a programming cycle that begins after the select byte has already been acknowledged. The bench drives the bus one bit at a time through its own master tasks. It can therefore issue a start after any number of clocks and raise the busy input between the acknowledge and the next data bit. It then checks that the partial byte raised no strobe and that the next start is decoded from scratch.

// File: rtl/efe_pkg.sv
package efe_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_SEL_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic loadTx;
    logic shiftTx;
    logic ackOn;
    logic relSda;
  } dpCtrlT;

  // events from datapath to control
  typedef struct packed {
    logic              startEv;
    logic              stopEv;
    logic              sclRise;
    logic              sclFall;
    logic              sdaBit;
    logic              byteFull;
    logic [BYTE_W-1:0] rxShift;
  } dpEvtT;
endpackage

// File: rtl/efe_sync.sv
module efe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/efe_datapath.sv
module efe_datapath
  import efe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] txByte,
  input  dpCtrlT            ctrl,
  output dpEvtT             evt,
  output logic              sdaOe
);
  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic byteFull;

  efe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sclSync_i (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  efe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sdaSync_i (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign byteFull = (cnt == CNT_W'(BYTE_W));

  // bit counter and receive shifter, both advanced on clock rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      rxShift <= '0;
    end else begin
      if (ctrl.clrCnt) cnt <= '0;
      else if (evt.sclRise && !byteFull) cnt <= cnt + 1'b1;
      if (evt.sclRise && !byteFull) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
    end
  end

  // transmit shifter and open-drain enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (ctrl.loadTx) begin
        txShift <= txByte;
        sdaOe   <= ~txByte[BYTE_W-1];
      end else if (ctrl.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
        sdaOe   <= ~txShift[BYTE_W-2];
      end else if (ctrl.ackOn) begin
        sdaOe   <= 1'b1;
      end else if (ctrl.relSda) begin
        sdaOe   <= 1'b0;
      end
    end
  end

  always_comb begin
    evt.startEv  = sclS & sclD & sdaD & ~sdaS;
    evt.stopEv   = sclS & sclD & ~sdaD & sdaS;
    evt.sclRise  = sclS & ~sclD;
    evt.sclFall  = ~sclS & sclD;
    evt.sdaBit   = sdaS;
    evt.byteFull = byteFull;
    evt.rxShift  = rxShift;
  end

  // R11: pull-down engages only while the clock is low
  a_r11_drive_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  // R2: counter never skips past a full byte
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    $past(byteFull) && !$past(ctrl.clrCnt) |-> byteFull);
endmodule

// File: rtl/efe_control.sv
module efe_control
  import efe_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpEvtT             evt,
  input  logic [1:0]        chipSel,
  input  logic              progBusy,
  output dpCtrlT            ctrl,
  output busStateT          busState,
  output logic              selStrobe,
  output logic              selHiAddr,
  output logic              selRead,
  output logic              rxStrobe,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txTake,
  output logic              stopStrobe
);
  busStateT nxtState;
  logic engaged, engNext, masterAck;
  logic selP, rxP, txP, stopP;
  logic idMatch;

  assign idMatch = (evt.rxShift[7:4] == DEV_ID) && (evt.rxShift[3:2] == chipSel);

  always_comb begin
    nxtState = busState;
    ctrl     = '0;
    selP     = 1'b0;
    rxP      = 1'b0;
    txP      = 1'b0;
    stopP    = 1'b0;
    engNext  = engaged;
    if (progBusy) begin
      nxtState    = ST_IDLE;
      ctrl.relSda = 1'b1;
      engNext     = 1'b0;
    end else if (evt.stopEv) begin
      nxtState    = ST_IDLE;
      ctrl.relSda = 1'b1;
      stopP       = engaged;
      engNext     = 1'b0;
    end else if (evt.startEv) begin
      nxtState    = ST_SEL;
      ctrl.clrCnt = 1'b1;
      ctrl.relSda = 1'b1;
    end else begin
      unique case (busState)
        ST_SEL: if (evt.sclFall && evt.byteFull) begin
          if (idMatch) begin
            nxtState   = ST_SEL_ACK;
            ctrl.ackOn = 1'b1;
            selP       = 1'b1;
            engNext    = 1'b1;
          end else begin
            nxtState   = ST_IDLE;
            engNext    = 1'b0;
          end
        end
        ST_SEL_ACK: if (evt.sclFall) begin
          ctrl.clrCnt = 1'b1;
          if (selRead) begin
            ctrl.loadTx = 1'b1;
            txP         = 1'b1;
            nxtState    = ST_RD;
          end else begin
            ctrl.relSda = 1'b1;
            nxtState    = ST_WR;
          end
        end
        ST_WR: if (evt.sclFall && evt.byteFull) begin
          ctrl.ackOn = 1'b1;
          rxP        = 1'b1;
          nxtState   = ST_WR_ACK;
        end
        ST_WR_ACK: if (evt.sclFall) begin
          ctrl.relSda = 1'b1;
          ctrl.clrCnt = 1'b1;
          nxtState    = ST_WR;
        end
        ST_RD: if (evt.sclFall) begin
          if (evt.byteFull) begin
            ctrl.relSda = 1'b1;
            nxtState    = ST_RD_ACK;
          end else begin
            ctrl.shiftTx = 1'b1;
          end
        end
        ST_RD_ACK: if (evt.sclFall) begin
          if (masterAck) begin
            ctrl.loadTx = 1'b1;
            ctrl.clrCnt = 1'b1;
            txP         = 1'b1;
            nxtState    = ST_RD;
          end else begin
            nxtState    = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState   <= ST_IDLE;
      engaged    <= 1'b0;
      masterAck  <= 1'b0;
      selStrobe  <= 1'b0;
      selHiAddr  <= 1'b0;
      selRead    <= 1'b0;
      rxStrobe   <= 1'b0;
      rxByte     <= '0;
      txTake     <= 1'b0;
      stopStrobe <= 1'b0;
    end else begin
      busState   <= nxtState;
      engaged    <= engNext;
      selStrobe  <= selP;
      rxStrobe   <= rxP;
      txTake     <= txP;
      stopStrobe <= stopP;
      if (busState == ST_RD_ACK && evt.sclRise) masterAck <= ~evt.sdaBit;
      if (selP) begin
        selHiAddr <= evt.rxShift[1];
        selRead   <= evt.rxShift[0];
      end
      if (rxP) rxByte <= evt.rxShift;
    end
  end

  // R1: a stop always lands in standby
  a_r1_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    evt.stopEv && !progBusy |=> busState == ST_IDLE);

  // R9: busy forces standby
  a_r9_busy_idle: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |=> busState == ST_IDLE && !selStrobe && !rxStrobe && !txTake);

  // R8: a start moves to select reception
  a_r8_start_sel: assert property (@(posedge clk) disable iff (!rstN)
    evt.startEv && !progBusy |=> busState == ST_SEL);
endmodule

// File: rtl/serial_mem_bus_front.sv
module serial_mem_bus_front
  import efe_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] chipSel,
  input  logic       progBusy,
  input  logic [7:0] txByte,
  output logic       sdaPullLow,
  output logic       selStrobe,
  output logic       selHiAddr,
  output logic       selRead,
  output logic       rxStrobe,
  output logic [7:0] rxByte,
  output logic       txTake,
  output logic       stopStrobe
);
  dpCtrlT   ctrl;
  dpEvtT    evt;
  busStateT busState;

  efe_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .txByte(txByte), .ctrl(ctrl), .evt(evt), .sdaOe(sdaPullLow));

  efe_control #(.DEV_ID(DEV_ID)) ctl_i (
    .clk(clk), .rstN(rstN), .evt(evt), .chipSel(chipSel),
    .progBusy(progBusy), .ctrl(ctrl), .busState(busState),
    .selStrobe(selStrobe), .selHiAddr(selHiAddr), .selRead(selRead),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .txTake(txTake),
    .stopStrobe(stopStrobe));

  // R3: a matched select is acknowledged at once
  a_r3_sel_acks: assert property (@(posedge clk) disable iff (!rstN)
    selStrobe |-> sdaPullLow);

  // R5: a received data byte is acknowledged at once
  a_r5_rx_acks: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |-> sdaPullLow);

  // R6: a loaded byte puts its top bit on the wire
  a_r6_tx_msb: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> sdaPullLow == ~$past(txByte[7]));

  // R7: released while the master answers a read byte
  a_r7_rd_ack_free: assert property (@(posedge clk) disable iff (!rstN)
    busState == ST_RD_ACK |-> !sdaPullLow);

  // R9: no drive the cycle after busy
  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |=> !sdaPullLow);

  // R10: nothing driven under reset
  always @(posedge clk) if (!rstN) a_r10_reset_quiet: assert (!sdaPullLow);
endmodule

// File: tb/serial_mem_bus_front_tb_top.sv
module serial_mem_bus_front_tb_top;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] chipSel = 2'b00;
  logic progBusy = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic sdaPullLow, selStrobe, selHiAddr, selRead, rxStrobe, txTake, stopStrobe;
  logic [7:0] rxByte;
  wire sdaBus = sdaM & ~sdaPullLow;

  int nChecks = 0, nFails = 0;
  int selCnt = 0, rxCnt = 0, txCnt = 0, stopCnt = 0;
  logic [7:0] rxLog [0:15];

  always #10 clk = ~clk;

  serial_mem_bus_front dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .chipSel(chipSel),
    .progBusy(progBusy), .txByte(txByte), .sdaPullLow(sdaPullLow),
    .selStrobe(selStrobe), .selHiAddr(selHiAddr), .selRead(selRead),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .txTake(txTake), .stopStrobe(stopStrobe));

  always @(posedge clk) begin
    if (selStrobe) selCnt++;
    if (txTake) txCnt++;
    if (stopStrobe) stopCnt++;
    if (rxStrobe) begin
      rxLog[rxCnt[3:0]] = rxByte;
      rxCnt++;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; w(HP); sclM = 1'b1; w(HP); sclM = 1'b0; w(2);
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; w(HP); sclM = 1'b1; w(HP/2); b = sdaBus; w(HP/2); sclM = 1'b0; w(2);
  endtask

  task automatic busStart();
    sdaM = 1'b1; w(HP); sclM = 1'b1; w(HP); sdaM = 1'b0; w(HP); sclM = 1'b0; w(2);
  endtask

  task automatic busStop();
    sdaM = 1'b0; w(HP); sclM = 1'b1; w(HP); sdaM = 1'b1; w(HP);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    readBit(b);
    acked = !b;
  endtask

  task automatic recvByte(input bit ackIt, input logic [7:0] nextTx, output logic [7:0] got);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      got[i] = b;
      if (i == 7) txByte = nextTx;
    end
    sendBit(!ackIt);
  endtask

  task automatic t_reset();
    bit a;
    chk(sdaPullLow == 1'b0, "R10 pull-down in reset", sdaPullLow, 0);
    busStart();
    sendByte(8'hA0, a);
    chk(!a, "R10 no ack under reset", a, 0);
    chk(selCnt == 0, "R10 no select under reset", selCnt, 0);
    busStop();
    rstN = 1'b1;
    w(5);
    chk(sdaPullLow == 1'b0, "R10 idle after reset", sdaPullLow, 0);
  endtask

  task automatic t_write();
    bit a; int s0 = selCnt, r0 = rxCnt, p0 = stopCnt;
    chipSel = 2'b00;
    busStart();
    sendByte(8'hA0, a);
    chk(a, "R3 select ack", a, 1);
    chk(selCnt == s0 + 1 && !selRead && !selHiAddr, "R3 select fields",
        {selRead, selHiAddr}, 0);
    sendByte(8'h3C, a);
    chk(a, "R5 data ack 1", a, 1);
    sendByte(8'hC5, a);
    chk(a, "R5 data ack 2", a, 1);
    chk(rxCnt == r0 + 2, "R2 rx count", rxCnt - r0, 2);
    chk(rxLog[r0[3:0]] == 8'h3C, "R2 rx byte 1", rxLog[r0[3:0]], 8'h3C);
    chk(rxLog[r0[3:0]+4'd1] == 8'hC5, "R2 rx byte 2", rxLog[r0[3:0]+4'd1], 8'hC5);
    busStop(); w(4);
    chk(stopCnt == p0 + 1, "R1 stop strobe", stopCnt - p0, 1);
  endtask

  task automatic t_badId();
    bit a; int s0 = selCnt, p0 = stopCnt;
    busStart();
    sendByte(8'hB0, a);
    chk(!a, "R4 wrong code no ack", a, 0);
    sendByte(8'hA0, a);
    chk(!a, "R4 ignored until start", a, 0);
    busStop(); w(4);
    chk(selCnt == s0 && stopCnt == p0, "R4 no strobes", selCnt - s0 + stopCnt - p0, 0);
  endtask

  task automatic t_chipSel();
    bit a;
    chipSel = 2'b01;
    busStart();
    sendByte(8'hA0, a);
    chk(!a, "R3 chip-enable mismatch no ack", a, 0);
    busStart();
    sendByte(8'hA6, a);
    chk(a, "R3 chip-enable match ack", a, 1);
    chk(selHiAddr && !selRead, "R3 high address bit", {selHiAddr, selRead}, 2);
    busStop();
    chipSel = 2'b10;
    busStart();
    sendByte(8'hA8, a);
    chk(a, "R3 chip-enable E2 match", a, 1);
    busStop();
    chipSel = 2'b00;
  endtask

  task automatic t_read();
    bit a; logic [7:0] d; logic b; int t0 = txCnt, p0 = stopCnt;
    busStart();
    sendByte(8'hA0, a);
    sendByte(8'h10, a);
    chk(a, "R5 address ack", a, 1);
    txByte = 8'h96;
    busStart();
    sendByte(8'hA1, a);
    chk(a && selRead, "R8 repeated start read select", {a, selRead}, 3);
    recvByte(1'b1, 8'h5A, d);
    chk(d == 8'h96, "R6 read byte 1", d, 8'h96);
    recvByte(1'b0, 8'hFF, d);
    chk(d == 8'h5A, "R6 read byte 2", d, 8'h5A);
    chk(txCnt == t0 + 2, "R6 take count", txCnt - t0, 2);
    readBit(b);
    chk(b == 1'b1 && !sdaPullLow, "R7 released after nack", b, 1);
    readBit(b);
    chk(b == 1'b1, "R7 still released", b, 1);
    busStop(); w(4);
    chk(stopCnt == p0 + 1, "R1 stop after read", stopCnt - p0, 1);
  endtask

  task automatic t_midRestart();
    bit a; int s0 = selCnt, r0 = rxCnt;
    busStart();
    sendByte(8'hA0, a);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    busStart();
    sendByte(8'hA0, a);
    chk(a && selCnt == s0 + 2, "R8 mid-byte restart select", selCnt - s0, 2);
    chk(rxCnt == r0, "R8 partial byte dropped", rxCnt - r0, 0);
    sendByte(8'h77, a);
    chk(a && rxLog[r0[3:0]] == 8'h77, "R8 data after restart", rxLog[r0[3:0]], 8'h77);
    busStop();
  endtask

  task automatic t_busy();
    bit a; int s0 = selCnt, r0 = rxCnt, p0;
    progBusy = 1'b1;
    busStart();
    sendByte(8'hA0, a);
    chk(!a && selCnt == s0, "R9 busy no select", a, 0);
    busStop();
    progBusy = 1'b0;
    busStart();
    sendByte(8'hA0, a);
    chk(a, "R9 select before busy", a, 1);
    p0 = stopCnt;
    progBusy = 1'b1;
    sendByte(8'h42, a);
    chk(!a && rxCnt == r0, "R9 abandoned mid transfer", rxCnt - r0, 0);
    progBusy = 1'b0;
    busStop(); w(4);
    chk(stopCnt == p0, "R9 no stop strobe", stopCnt - p0, 0);
    busStart();
    sendByte(8'hA0, a);
    chk(a, "R9 responds after busy", a, 1);
    busStop();
  endtask

  initial begin
    w(3);
    t_reset();
    t_write();
    t_badId();
    t_chipSel();
    t_read();
    t_midRestart();
    t_busy();
    w(10);
    summary();
    $finish;
  end
endmodule